// File: doc/BRIEF.md
# Indirect Interrupt-Controller Register Window

This block is the register front end of an I/O interrupt controller. A 32-bit bus slave exposes two word-sized locations. The first, at byte offset 0x00, is a select register that holds a register index. The second, at byte offset 0x10, is a data window. Each access to the data window reaches the register named by the low byte of the select register. Behind the window are an identification register, a version register, an arbitration register and a redirection table. The table holds `ENTRIES` entries of 64 bits each, and every entry is reached as two 32-bit halves.

The block stores the table and keeps the ID field. It keeps the remote-IRR and delivery-status bits of every entry out of software's reach: those two bits come from the pin-delivery engine through per-entry status inputs. All entries are presented in parallel to that engine on one flat output bus. Read data is registered and appears one cycle after the request, together with a one-cycle valid strobe.

Top module: `intc_regwin`

## Requirements
- R1: A 32-bit write to byte offset 0x00 stores all 32 bits in the select register. A 32-bit read of offset 0x00 returns the full stored value.
- R2: Only accesses with size code 2 (4 bytes) at offsets 0x00 or 0x10 take effect. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Any other size or offset returns 0 on a read and changes nothing on a write.
- R3: Every read request produces `bus_rvalid` high for exactly the following cycle, with `bus_rdata` valid in that same cycle. `bus_rvalid` is low in every other cycle.
- R4: The window index is bits 7:0 of the select register, and bits 31:8 are ignored. Index 0x01 is the version register. It reads ((ENTRIES-1) << 16) | 0x11, which is 0x00170011 for 24 entries, and writes leave it unchanged.
- R5: Index 0x00 is the identification register. A write keeps only bits 27:24 (the ID field), and the other bits read 0. Index 0x02 is the arbitration register. It reads the same word as index 0x00, and writes to it are ignored.
- R6: Indices 0x10 to 0x10+2*ENTRIES-1 reach the table. The pin is (index-0x10)/2. An even index maps to entry bits 31:0 and an odd index to bits 63:32. A write replaces only the addressed half of that single entry.
- R7: Bit 12 (delivery status) and bit 14 (remote IRR) of entry p always equal `dlvs_i[p]` and `rirr_i[p]`, on reads and on `entry_o`. Window writes never change them.
- R8: After reset every entry is 0x0001000000010000, so bits 16 and 48 are set. The select register and the ID field are 0.
- R9: A window index that is not 0x00 to 0x02 and not inside the table reads 0, and writes to it change nothing.
- R10: `entry_o[64*p +: 64]` shows entry p at all times. A window write shows there from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_size | input | 2 | Access size code (2 = 4 bytes) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data strobe |
| rirr_i | input | ENTRIES | Remote-IRR status per entry from the delivery engine |
| dlvs_i | input | ENTRIES | Delivery status per entry from the delivery engine |
| entry_o | output | 64*ENTRIES | All redirection entries, entry p at bits 64p+63:64p |

## Verification
Two functions can meet in one cycle: a software write to the low half of an entry, and a change of that entry's status bits by the delivery engine. The bench forces this by raising `rirr_i` and `dlvs_i` for an entry in the same cycle that the window writes zeros to its low half. It then reads the half back. The write must take the writable bits, and bits 12 and 14 must show the engine's new values. A reference model in the bench checks this against `entry_o` on every clock and against the read data.

// File: rtl/intc_regwin_pkg.sv
package intc_regwin_pkg;

   localparam int WORD_W  = 32;
   localparam int ENTRY_W = 64;

   // access size code for a full 32-bit word
   localparam logic [1:0] SZ_WORD = 2'd2;

   // window indices
   localparam logic [7:0] IX_ID  = 8'h00;
   localparam logic [7:0] IX_VER = 8'h01;
   localparam logic [7:0] IX_ARB = 8'h02;
   localparam logic [7:0] IX_TBL = 8'h10;

   // engine-owned bits of the low half
   localparam int B_DLVS = 12;
   localparam int B_RIRR = 14;
   localparam logic [31:0] LO_RO_MASK = (32'h1 << B_DLVS) | (32'h1 << B_RIRR);

   // each half resets with its mask bit set
   localparam logic [31:0] HALF_RESET = 32'h0001_0000;

   localparam int VER_CNT_LSB = 16;
   localparam logic [31:0] VER_CODE = 32'h0000_0011;

   function automatic logic [31:0] ver_word(input int n);
      return (32'(n - 1) << VER_CNT_LSB) | VER_CODE;
   endfunction

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_SEL  = 2'd1,
      ACC_WIN  = 2'd2
   } acc_tgt_e;

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
   import intc_regwin_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int SEL_OFF = 'h00,
   parameter int WIN_OFF = 'h10
) (
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output acc_tgt_e          tgt,
   output logic              rd_req,
   output logic              wr_sel,
   output logic              wr_win
);

   localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_OFF);
   localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(WIN_OFF);

   logic size_ok;

   always_comb begin
      size_ok = (size == SZ_WORD);
      tgt     = ACC_NONE;
      if (valid && size_ok) begin
         if (addr == SEL_A)      tgt = ACC_SEL;
         else if (addr == WIN_A) tgt = ACC_WIN;
      end
   end

   assign rd_req = valid && !write;
   assign wr_sel = valid && write && (tgt == ACC_SEL);
   assign wr_win = valid && write && (tgt == ACC_WIN);

endmodule

// File: rtl/regwin_globals.sv
module regwin_globals
   import intc_regwin_pkg::*;
#(
   parameter int ID_W   = 4,
   parameter int ID_LSB = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic              wr_id,
   input  logic [WORD_W-1:0] sel_wdata,
   input  logic [ID_W-1:0]   id_wdata,
   output logic [WORD_W-1:0] sel_q,
   output logic [WORD_W-1:0] id_word
);

   logic [ID_W-1:0] id_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (wr_sel) begin
         sel_q <= sel_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q <= '0;
      end else if (wr_id) begin
         id_q <= id_wdata;
      end
   end

   assign id_word = WORD_W'(id_q) << ID_LSB;

endmodule

// File: rtl/regwin_table.sv
module regwin_table
   import intc_regwin_pkg::*;
#(
   parameter int ENTRIES = 24
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_win,
   input  logic [7:0]                 idx,
   input  logic [WORD_W-1:0]          wdata,
   input  logic [ENTRIES-1:0]         rirr_i,
   input  logic [ENTRIES-1:0]         dlvs_i,
   output logic [ENTRIES*ENTRY_W-1:0] entry_o,
   output logic                       tbl_hit,
   output logic [WORD_W-1:0]          tbl_rdata
);

   localparam int SPAN = 2 * ENTRIES;
   localparam logic [8:0] TBL_END = 9'(IX_TBL) + 9'(SPAN);

   logic [7:0] offs;
   logic [6:0] pin_ix;
   logic       upper;

   logic [WORD_W-1:0] lo_view [ENTRIES];
   logic [WORD_W-1:0] hi_view [ENTRIES];

   always_comb begin
      tbl_hit = ({1'b0, idx} >= {1'b0, IX_TBL}) && ({1'b0, idx} < TBL_END);
      offs    = idx - IX_TBL;
      pin_ix  = offs[7:1];
      upper   = offs[0];
   end

   for (genvar p = 0; p < ENTRIES; p++) begin : g_ent
      logic [WORD_W-1:0] lo_q;
      logic [WORD_W-1:0] hi_q;
      logic              hit_p;
      logic [WORD_W-1:0] status;

      assign hit_p = wr_win && tbl_hit && (int'(pin_ix) == p);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= HALF_RESET & ~LO_RO_MASK;
         end else if (hit_p && !upper) begin
            lo_q <= wdata & ~LO_RO_MASK;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_q <= HALF_RESET;
         end else if (hit_p && upper) begin
            hi_q <= wdata;
         end
      end

      assign status = (WORD_W'(rirr_i[p]) << B_RIRR) | (WORD_W'(dlvs_i[p]) << B_DLVS);
      assign lo_view[p] = lo_q | status;
      assign hi_view[p] = hi_q;
      assign entry_o[p*ENTRY_W +: ENTRY_W] = {hi_view[p], lo_view[p]};
   end

   always_comb begin
      tbl_rdata = '0;
      for (int p = 0; p < ENTRIES; p++) begin
         if (tbl_hit && (int'(pin_ix) == p)) begin
            tbl_rdata = upper ? hi_view[p] : lo_view[p];
         end
      end
   end

endmodule

// File: rtl/regwin_rdmux.sv
module regwin_rdmux
   import intc_regwin_pkg::*;
#(
   parameter int ENTRIES = 24
) (
   input  acc_tgt_e          tgt,
   input  logic              rd_req,
   input  logic [7:0]        idx,
   input  logic [WORD_W-1:0] sel_q,
   input  logic [WORD_W-1:0] id_word,
   input  logic              tbl_hit,
   input  logic [WORD_W-1:0] tbl_rdata,
   output logic [WORD_W-1:0] rdata_d
);

   localparam logic [WORD_W-1:0] VER_VAL = ver_word(ENTRIES);

   logic [WORD_W-1:0] win_val;

   always_comb begin
      unique case (idx)
         IX_ID, IX_ARB: win_val = id_word;
         IX_VER:        win_val = VER_VAL;
         default:       win_val = tbl_hit ? tbl_rdata : '0;
      endcase
   end

   always_comb begin
      rdata_d = '0;
      if (rd_req) begin
         case (tgt)
            ACC_SEL: rdata_d = sel_q;
            ACC_WIN: rdata_d = win_val;
            default: rdata_d = '0;
         endcase
      end
   end

endmodule

// File: rtl/intc_regwin.sv
module intc_regwin
   import intc_regwin_pkg::*;
#(
   parameter int ENTRIES = 24,
   parameter int ADDR_W  = 8,
   parameter int SEL_OFF = 'h00,
   parameter int WIN_OFF = 'h10,
   parameter int ID_W    = 4,
   parameter int ID_LSB  = 24
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_valid,
   input  logic                       bus_write,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [1:0]                 bus_size,
   input  logic [31:0]                bus_wdata,
   output logic [31:0]                bus_rdata,
   output logic                       bus_rvalid,
   input  logic [ENTRIES-1:0]         rirr_i,
   input  logic [ENTRIES-1:0]         dlvs_i,
   output logic [ENTRIES*64-1:0]      entry_o
);

   // elaboration-time parameter checks
   if (ENTRIES < 1 || (16 + 2 * ENTRIES) > 256) begin : g_bad_entries
      $error("intc_regwin: ENTRIES must fit the 8-bit window index");
   end
   if (ID_W < 1 || (ID_LSB + ID_W) > 32) begin : g_bad_id
      $error("intc_regwin: ID field must lie inside a 32-bit word");
   end
   if (ADDR_W < 5 || SEL_OFF == WIN_OFF) begin : g_bad_addr
      $error("intc_regwin: offsets must be distinct and addressable");
   end

   acc_tgt_e    tgt;
   logic        rd_req;
   logic        wr_sel;
   logic        wr_win;
   logic [31:0] sel_q;
   logic [31:0] id_word;
   logic [7:0]  idx;
   logic        wr_id;
   logic        tbl_hit;
   logic [31:0] tbl_rdata;
   logic [31:0] rdata_d;

   regwin_decode #(
      .ADDR_W  (ADDR_W),
      .SEL_OFF (SEL_OFF),
      .WIN_OFF (WIN_OFF)
   ) u_dec (
      .valid  (bus_valid),
      .write  (bus_write),
      .addr   (bus_addr),
      .size   (bus_size),
      .tgt    (tgt),
      .rd_req (rd_req),
      .wr_sel (wr_sel),
      .wr_win (wr_win)
   );

   assign idx   = sel_q[7:0];
   assign wr_id = wr_win && (idx == IX_ID);

   regwin_globals #(
      .ID_W   (ID_W),
      .ID_LSB (ID_LSB)
   ) u_glb (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (wr_sel),
      .wr_id     (wr_id),
      .sel_wdata (bus_wdata),
      .id_wdata  (bus_wdata[ID_LSB +: ID_W]),
      .sel_q     (sel_q),
      .id_word   (id_word)
   );

   regwin_table #(
      .ENTRIES (ENTRIES)
   ) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_win    (wr_win),
      .idx       (idx),
      .wdata     (bus_wdata),
      .rirr_i    (rirr_i),
      .dlvs_i    (dlvs_i),
      .entry_o   (entry_o),
      .tbl_hit   (tbl_hit),
      .tbl_rdata (tbl_rdata)
   );

   regwin_rdmux #(
      .ENTRIES (ENTRIES)
   ) u_rd (
      .tgt       (tgt),
      .rd_req    (rd_req),
      .idx       (idx),
      .sel_q     (sel_q),
      .id_word   (id_word),
      .tbl_hit   (tbl_hit),
      .tbl_rdata (tbl_rdata),
      .rdata_d   (rdata_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rdata  <= rdata_d;
         bus_rvalid <= rd_req;
      end
   end

endmodule

// File: rtl/intc_regwin_chk.sv
module intc_regwin_chk #(
   parameter int ENTRIES = 24,
   parameter int ADDR_W  = 8,
   parameter int SEL_OFF = 'h00,
   parameter int WIN_OFF = 'h10
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_valid,
   input logic                  bus_write,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [1:0]            bus_size,
   input logic [31:0]           bus_rdata,
   input logic                  bus_rvalid,
   input logic [ENTRIES-1:0]    rirr_i,
   input logic [ENTRIES-1:0]    dlvs_i,
   input logic [ENTRIES*64-1:0] entry_o,
   input logic [31:0]           sel_q
);

   function automatic logic [ENTRIES*64-1:0] ro_bits();
      logic [ENTRIES*64-1:0] m;
      m = '0;
      for (int p = 0; p < ENTRIES; p++) begin
         m[p*64 + 12] = 1'b1;
         m[p*64 + 14] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [ENTRIES*64-1:0] RO_M  = ro_bits();
   localparam logic [31:0]           VER_V = (32'(ENTRIES - 1) << 16) | 32'h11;

   logic rd_now;
   logic sel_wr_now;
   logic ver_rd_now;
   logic any_wr_now;

   assign rd_now     = bus_valid && !bus_write;
   assign any_wr_now = bus_valid && bus_write;
   assign sel_wr_now = any_wr_now && (bus_addr == ADDR_W'(SEL_OFF)) && (bus_size == 2'd2);
   assign ver_rd_now = rd_now && (bus_addr == ADDR_W'(WIN_OFF)) && (bus_size == 2'd2)
                       && (sel_q[7:0] == 8'h01);

   a_r3_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_now |=> bus_rvalid);

   a_r3_no_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_now |=> !bus_rvalid);

   a_r2_bad_size_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && bus_size != 2'd2) |=> (bus_rdata == 32'h0));

   a_r1_sel_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_wr_now |=> $stable(sel_q));

   a_r4_version_word: assert property (@(posedge clk) disable iff (!rst_n)
      ver_rd_now |=> (bus_rdata == VER_V));

   a_r10_entries_move_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !any_wr_now |=> (((entry_o ^ $past(entry_o)) & ~RO_M) == '0));

   a_r7_ro_bits_follow_engine: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(rirr_i) && $stable(dlvs_i)) |-> (((entry_o ^ $past(entry_o)) & RO_M) == '0));

endmodule

bind intc_regwin intc_regwin_chk #(
   .ENTRIES (ENTRIES),
   .ADDR_W  (ADDR_W),
   .SEL_OFF (SEL_OFF),
   .WIN_OFF (WIN_OFF)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_valid  (bus_valid),
   .bus_write  (bus_write),
   .bus_addr   (bus_addr),
   .bus_size   (bus_size),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .rirr_i     (rirr_i),
   .dlvs_i     (dlvs_i),
   .entry_o    (entry_o),
   .sel_q      (sel_q)
);

// File: tb/tb_intc_regwin.sv
`timescale 1ns/1ps
module tb_intc_regwin;

   localparam int N = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_write = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [1:0]    bus_size = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_rvalid;
   logic [N-1:0]  rirr_i = '0;
   logic [N-1:0]  dlvs_i = '0;
   logic [N*64-1:0] entry_o;

   always #4 clk = ~clk;   // 125 MHz

   intc_regwin #(.ENTRIES(N)) dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .rirr_i(rirr_i),
      .dlvs_i(dlvs_i), .entry_o(entry_o)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_sel;
   logic [3:0]  m_id;
   logic [31:0] m_lo [N];
   logic [31:0] m_hi [N];
   logic        m_rvalid;
   logic [31:0] m_rdata;
   string       m_tag;
   bit          m_wrote;
   bit          run = 0;
   bit          done = 0;
   int          n_chk = 0;
   int          n_fail = 0;

   function automatic logic [31:0] lo_full(int p);
      logic [31:0] v;
      v = m_lo[p];
      v[14] = rirr_i[p];
      v[12] = dlvs_i[p];
      return v;
   endfunction

   function automatic logic [31:0] m_read(logic [7:0] ix);
      int p;
      if (ix == 8'h00 || ix == 8'h02) return {4'h0, m_id, 24'h0};
      if (ix == 8'h01) return ((N - 1) << 16) | 32'h11;
      if (ix >= 8'h10 && int'(ix) < 16 + 2 * N) begin
         p = (int'(ix) - 16) / 2;
         return ix[0] ? m_hi[p] : lo_full(p);
      end
      return 32'h0;
   endfunction

   function automatic string tag_for(logic [7:0] ix);
      int p;
      if (ix == 8'h00 || ix == 8'h02) return "R5";
      if (ix == 8'h01) return "R4";
      if (ix >= 8'h10 && int'(ix) < 16 + 2 * N) begin
         p = (int'(ix) - 16) / 2;
         if (!ix[0] && (rirr_i[p] || dlvs_i[p])) return "R7";
         return "R6";
      end
      return "R9";
   endfunction

   always @(posedge clk or negedge rst_n) begin
      bit ok;
      int p;
      if (!rst_n) begin
         m_sel = '0; m_id = '0; m_rvalid = 0; m_rdata = '0; m_tag = "R8"; m_wrote = 0;
         for (int i = 0; i < N; i++) begin
            m_lo[i] = 32'h0001_0000;
            m_hi[i] = 32'h0001_0000;
         end
      end else begin
         ok = bus_valid && bus_size == 2'd2 && (bus_addr == 8'h00 || bus_addr == 8'h10);
         m_rvalid = bus_valid && !bus_write;
         if (m_rvalid) begin
            if (!ok) begin m_rdata = 0; m_tag = "R2"; end
            else if (bus_addr == 8'h00) begin m_rdata = m_sel; m_tag = "R1"; end
            else begin m_rdata = m_read(m_sel[7:0]); m_tag = tag_for(m_sel[7:0]); end
         end
         if (bus_valid && bus_write && ok) begin
            m_wrote = 1;
            if (bus_addr == 8'h00) m_sel = bus_wdata;
            else if (m_sel[7:0] == 8'h00) m_id = bus_wdata[27:24];
            else if (m_sel[7:0] >= 8'h10 && int'(m_sel[7:0]) < 16 + 2 * N) begin
               p = (int'(m_sel[7:0]) - 16) / 2;
               if (m_sel[0]) m_hi[p] = bus_wdata;
               else          m_lo[p] = bus_wdata & ~32'h0000_5000;
            end
         end
      end
   end

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (run && rst_n && !done) begin
         int bad;
         chk(bus_rvalid === m_rvalid, "R3", 64'(bus_rvalid), 64'(m_rvalid));
         if (m_rvalid) chk(bus_rdata === m_rdata, m_tag, 64'(bus_rdata), 64'(m_rdata));
         bad = -1;
         for (int p = 0; p < N; p++)
            if (bad < 0 && entry_o[p*64 +: 64] !== {m_hi[p], lo_full(p)}) bad = p;
         if (bad < 0) chk(1'b1, m_wrote ? "R10" : "R8", 0, 0);
         else chk(1'b0, m_wrote ? "R10" : "R8", entry_o[bad*64 +: 64], {m_hi[bad], lo_full(bad)});
      end
   end

   // ---------------- stimulus ----------------
   task automatic acc(bit wr, logic [7:0] a, logic [1:0] sz, logic [31:0] d);
      bus_valid = 1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
      @(posedge clk); #1;
      bus_valid = 0; bus_write = 0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
   endtask

   task automatic wsel(logic [31:0] v); acc(1, 8'h00, 2'd2, v); endtask
   task automatic rsel();               acc(0, 8'h00, 2'd2, 0); endtask
   task automatic wwin(logic [31:0] v); acc(1, 8'h10, 2'd2, v); endtask
   task automatic rwin();               acc(0, 8'h10, 2'd2, 0); endtask

   task automatic fin();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      fin();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1; run = 1;
      @(posedge clk); #1;
      // R8: reset values through the window
      rsel();
      wsel(32'h10); rwin(); wsel(32'h11); rwin();
      wsel(32'h10 + 2*(N-1)); rwin();
      wsel(32'h00); rwin();
      // R1: full select readback
      wsel(32'hDEAD_BE01); rsel();
      // R4: upper select bits ignored, version read-only
      rwin(); wwin(32'hFFFF_FFFF); rwin();
      // R5: ID field and arbitration mirror
      wsel(32'h00); wwin(32'hFFFF_FFFF); rwin();
      wsel(32'h02); rwin(); wwin(32'h0); rwin();
      wsel(32'h00); rwin();
      wwin(32'h0A00_0000); wsel(32'h02); rwin();
      // R6: halves of entry 5
      wsel(32'h10 + 10); wwin(32'hFFFF_FFFF); rwin();
      wsel(32'h10 + 11); wwin(32'hAB00_1234); rwin();
      wsel(32'h10 + 10); rwin();
      // R6: first and last entries
      wsel(32'h10); wwin(32'h0000_A031); wsel(32'h11); wwin(32'h0700_0000);
      wsel(32'h10 + 2*(N-1) + 1); wwin(32'h5500_0000); rwin();
      wsel(32'h7700_0010); rwin();
      // R7: engine status changes in the same cycle as a low-half write
      wsel(32'h10 + 10);
      rirr_i[5] = 1; dlvs_i[5] = 1;
      wwin(32'h0000_0000); rwin();
      wwin(32'hFFFF_FFFF); rwin();
      rirr_i[5] = 0; rwin();
      dlvs_i = '1; rwin(); dlvs_i = '0;
      // R2: wrong size or offset
      acc(1, 8'h00, 2'd1, 32'h0000_0055); rsel();
      acc(1, 8'h00, 2'd3, 32'h0000_0066); rsel();
      acc(0, 8'h10, 2'd0, 0); acc(0, 8'h04, 2'd2, 0);
      acc(1, 8'h14, 2'd2, 32'h1234_5678); rwin();
      acc(1, 8'h10, 2'd1, 32'h0000_0000); rwin();
      // R9: undefined indices
      wsel(32'h05); rwin(); wwin(32'hFFFF_FFFF); rwin();
      wsel(32'h10 + 2*N); rwin(); wwin(32'hFFFF_FFFF); rwin();
      wsel(32'hFF); rwin(); wwin(32'h1); rwin();
      // R3: back-to-back reads then idle
      wsel(32'h01); rwin(); rwin(); rsel();
      repeat (3) @(posedge clk);
      #1 fin();
   end

endmodule